// File: doc/BRIEF.md
# Associative ID Translation Buffer

A small fully associative table that turns global identifiers (method numbers, object names) into local addresses for a message handler. Each entry holds a key and a value; every lookup compares the incoming key against all valid entries in the same cycle. Three operations are offered on one request port: translate returns the value or raises a miss flag that the handler uses to trap into software; enter installs a key/value pair, overwriting the value of a key already held or claiming a slot, evicting an older entry when none is free; probe reports presence and value without touching the replacement order.

Requests are accepted one per cycle and each produces a registered response on the following cycle. A two-state response machine drives the response strobe. In `S_IDLE` no response is shown. `T_ACCEPT` moves to `S_RESP` on a valid request. `T_CHAIN` keeps `S_RESP` when another request arrives. `T_DRAIN` returns to `S_IDLE` when none does, and `T_REST` holds `S_IDLE`. Free slots are claimed lowest index first. Once all are valid, a round-robin pointer chooses the victim and advances only on an eviction.

Top module: `xl_assoc_buf`

## Requirements
- R1: After reset no response is shown (rsp_valid=0) and the table is empty, so any translate misses.
- R2: Operation codes on req_op are 0 translate, 1 enter, 2 probe, 3 reserved. A translate of a held key responds with rsp_hit=1, rsp_miss=0 and rsp_value equal to the stored value.
- R3: A translate of an absent key responds with rsp_miss=1, rsp_hit=0 and rsp_value=0.
- R4: An enter of a new key while a slot is free takes the lowest free slot, responds with rsp_hit=0 and rsp_evict=0, and the key then translates to the new value.
- R5: An enter of a held key rewrites its value in place: rsp_hit=1, rsp_evict=0, and no slot is consumed, so the next eviction order is unchanged.
- R6: An enter of a new key into a full table evicts in round-robin slot order starting at slot 0, responds with rsp_evict=1 and rsp_evict_key equal to the displaced key, which then misses.
- R7: A probe responds with rsp_hit and rsp_value like a translate but never raises rsp_miss, changes no entry and does not move the replacement pointer.
- R8: Every request with code 0 to 2 produces exactly one rsp_valid pulse in the next cycle; code 3 produces no response and changes no entry.
- R9: At most one entry matches any key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (0 translate, 1 enter, 2 probe) |
| req_key | input | KEY_W | Global identifier |
| req_value | input | VAL_W | Local address to install on enter |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Key was present |
| rsp_miss | output | 1 | Translate found no entry |
| rsp_value | output | VAL_W | Looked-up value, or installed value on enter |
| rsp_evict | output | 1 | Enter displaced a valid entry |
| rsp_evict_key | output | KEY_W | Key of the displaced entry |

## Verification
A corrupted valid bit or stored key shows up at the first translate or probe of that key, one cycle later, as a false miss or a wrong value. A replacement pointer that drifts, moves on a probe, or moves on an in-place rewrite appears only at the next eviction, as a wrong rsp_evict_key. The bench therefore fills the table, mixes probes and rewrites between evictions, and checks every displaced key. A duplicate entry would surface as a multiple match on the following lookup.

// File: rtl/xl_pkg.sv
package xl_pkg;
    typedef enum logic [1:0] {
        OP_XLATE = 2'd0,
        OP_ENTER = 2'd1,
        OP_PROBE = 2'd2,
        OP_RSVD  = 2'd3
    } xl_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } xl_state_e;
endpackage

// File: rtl/xl_match.sv
module xl_match #(
    parameter int KEY_W = 16,
    parameter int VAL_W = 24,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [KEY_W-1:0] key,
    input  logic [DEPTH-1:0] valid,
    input  logic [KEY_W-1:0] keys [DEPTH],
    input  logic [VAL_W-1:0] vals [DEPTH],
    output logic [DEPTH-1:0] hit_vec,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [VAL_W-1:0] hit_val
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (keys[g] == key);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        hit_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
                hit_val = hit_val | vals[i];
            end
        end
    end
endmodule

// File: rtl/xl_victim.sv
module xl_victim #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid,
    input  logic             evict_fire,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_free
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign victim_free = ~&valid;
    assign victim_idx  = victim_free ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (evict_fire) begin
            rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_comb begin
        if (rst_n) begin
            assert (int'(rr_q) < DEPTH)
                else $error("p_ptr_range_r6: pointer out of range");
        end
    end
endmodule

// File: rtl/xl_assoc_buf.sv
module xl_assoc_buf
    import xl_pkg::*;
#(
    parameter int KEY_W = 16,
    parameter int VAL_W = 24,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [KEY_W-1:0] req_key,
    input  logic [VAL_W-1:0] req_value,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [VAL_W-1:0] rsp_value,
    output logic             rsp_evict,
    output logic [KEY_W-1:0] rsp_evict_key
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [KEY_W-1:0] key_q [DEPTH];
    logic [VAL_W-1:0] val_q [DEPTH];
    logic [DEPTH-1:0] valid_q;

    logic [DEPTH-1:0] hit_vec;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [VAL_W-1:0] hit_val;
    logic [IDX_W-1:0] victim_idx;
    logic             victim_free;

    xl_op_e    op;
    xl_state_e state_q, state_d;
    logic      accept, do_enter, do_evict;
    logic [IDX_W-1:0] wr_idx;

    logic             hit_q, miss_q, evict_q;
    logic [VAL_W-1:0] value_q;
    logic [KEY_W-1:0] evkey_q;

    assign op       = xl_op_e'(req_op);
    assign accept   = req_valid && (op != OP_RSVD);
    assign do_enter = req_valid && (op == OP_ENTER);
    assign do_evict = do_enter && !hit && !victim_free;
    assign wr_idx   = hit ? hit_idx : victim_idx;

    xl_match #(.KEY_W(KEY_W), .VAL_W(VAL_W), .DEPTH(DEPTH)) i_match (
        .key     (req_key),
        .valid   (valid_q),
        .keys    (key_q),
        .vals    (val_q),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_idx (hit_idx),
        .hit_val (hit_val)
    );

    xl_victim #(.DEPTH(DEPTH)) i_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (valid_q),
        .evict_fire  (do_evict),
        .victim_idx  (victim_idx),
        .victim_free (victim_free)
    );

    // Next-state logic: T_ACCEPT, T_CHAIN, T_DRAIN, T_REST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = accept ? S_RESP : S_IDLE;
            S_RESP: state_d = accept ? S_RESP : S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Table storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (do_enter) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_enter) begin
            key_q[wr_idx] <= req_key;
            val_q[wr_idx] <= req_value;
        end
    end

    // Response payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            miss_q  <= 1'b0;
            evict_q <= 1'b0;
            value_q <= '0;
            evkey_q <= '0;
        end else begin
            hit_q   <= accept && hit;
            miss_q  <= req_valid && (op == OP_XLATE) && !hit;
            evict_q <= do_evict;
            value_q <= do_enter ? req_value : (accept ? hit_val : '0);
            evkey_q <= do_evict ? key_q[victim_idx] : '0;
        end
    end

    // Output process
    always_comb begin
        rsp_valid     = 1'b0;
        rsp_hit       = 1'b0;
        rsp_miss      = 1'b0;
        rsp_value     = '0;
        rsp_evict     = 1'b0;
        rsp_evict_key = '0;
        unique case (state_q)
            S_IDLE: ;
            S_RESP: begin
                rsp_valid     = 1'b1;
                rsp_hit       = hit_q;
                rsp_miss      = miss_q;
                rsp_value     = value_q;
                rsp_evict     = evict_q;
                rsp_evict_key = evkey_q;
            end
        endcase
    end

    p_rsp_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid && (req_op != 2'd3)));

    p_miss_xlate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_valid && !rsp_hit && $past(req_op) == 2'd0));

    p_evict_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_evict |-> ($past(&valid_q) && !rsp_hit && $past(req_op) == 2'd1));

    p_unique_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_probe_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op == 2'd2) |-> $stable(valid_q));
endmodule

// File: tb/test_xl_assoc_buf.sv
module test_xl_assoc_buf;
    localparam int KW = 16;
    localparam int VW = 24;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [KW-1:0] req_key = '0;
    logic [VW-1:0] req_value = '0;
    logic          rsp_valid, rsp_hit, rsp_miss, rsp_evict;
    logic [VW-1:0] rsp_value;
    logic [KW-1:0] rsp_evict_key;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xl_assoc_buf #(.KEY_W(KW), .VAL_W(VW), .DEPTH(DP)) i_xl_assoc_buf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_key(req_key), .req_value(req_value), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_value(rsp_value),
        .rsp_evict(rsp_evict), .rsp_evict_key(rsp_evict_key)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one request, sample the response one cycle later
    task automatic issue(input logic [1:0] op, input logic [KW-1:0] k, input logic [VW-1:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_key = k; req_value = v;
        @(posedge clk);
        #1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input int vld, input int h, input int m,
                              input int val, input int ev, input int evk);
        chk(tag, "rsp_valid", int'(rsp_valid), vld);
        chk(tag, "rsp_hit", int'(rsp_hit), h);
        chk(tag, "rsp_miss", int'(rsp_miss), m);
        chk(tag, "rsp_value", int'(rsp_value), val);
        chk(tag, "rsp_evict", int'(rsp_evict), ev);
        if (ev != 0) chk(tag, "rsp_evict_key", int'(rsp_evict_key), evk);
    endtask

    // Issue and check at the cycle after the sampling edge (registered response)
    task automatic op_check(input string tag, input logic [1:0] op, input logic [KW-1:0] k,
                            input logic [VW-1:0] v, input int h, input int m, input int val,
                            input int ev, input int evk);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_key = k; req_value = v;
        @(posedge clk);
        #1;
        expect_rsp(tag, (op == 2'd3) ? 0 : 1, h, m, val, ev, evk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        op_check("R1", 2'd0, 16'h0100, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < DP; i++) begin
            op_check("R4", 2'd1, KW'(16'h0100 + i), VW'(24'hA000 + i), 0, 0,
                     24'hA000 + i, 0, 0);
        end
        for (int i = 0; i < DP; i++) begin
            op_check("R2", 2'd0, KW'(16'h0100 + i), 0, 1, 0, 24'hA000 + i, 0, 0);
        end
        op_check("R3", 2'd0, 16'h0777, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic t_probe;
        op_check("R7", 2'd2, 16'h0103, 0, 1, 0, 24'hA003, 0, 0);
        op_check("R7", 2'd2, 16'h0555, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_rewrite;
        op_check("R5", 2'd1, 16'h0105, 24'hBEEF05, 1, 0, 24'hBEEF05, 0, 0);
        op_check("R5", 2'd0, 16'h0105, 0, 1, 0, 24'hBEEF05, 0, 0);
    endtask

    task automatic t_evict;
        op_check("R6", 2'd1, 16'h0200, 24'hC00000, 0, 0, 24'hC00000, 1, 16'h0100);
        op_check("R7", 2'd2, 16'h0101, 0, 1, 0, 24'hA001, 0, 0);
        op_check("R7", 2'd2, 16'h0200, 0, 1, 0, 24'hC00000, 0, 0);
        op_check("R6", 2'd1, 16'h0201, 24'hC00001, 0, 0, 24'hC00001, 1, 16'h0101);
        op_check("R5", 2'd1, 16'h0107, 24'hD00007, 1, 0, 24'hD00007, 0, 0);
        op_check("R6", 2'd1, 16'h0202, 24'hC00002, 0, 0, 24'hC00002, 1, 16'h0102);
        op_check("R6", 2'd0, 16'h0100, 0, 0, 1, 0, 0, 0);
        op_check("R6", 2'd0, 16'h0102, 0, 0, 1, 0, 0, 0);
        op_check("R6", 2'd0, 16'h0201, 0, 1, 0, 24'hC00001, 0, 0);
        op_check("R9", 2'd0, 16'h0107, 0, 1, 0, 24'hD00007, 0, 0);
    endtask

    task automatic t_reserved;
        op_check("R8", 2'd3, 16'h0300, 24'h123456, 0, 0, 0, 0, 0);
        op_check("R8", 2'd2, 16'h0300, 0, 0, 0, 0, 0, 0);
        // a reserved code causes no eviction either: next eviction is slot 3
        op_check("R8", 2'd1, 16'h0203, 24'hC00003, 0, 0, 24'hC00003, 1, 16'h0103);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_key = 16'h0400; req_value = 24'hE00000;
        @(posedge clk);
        #1;
        expect_rsp("R8", 1, 0, 0, 24'hE00000, 1, 16'h0104);
        @(negedge clk);
        req_op = 2'd0;
        @(posedge clk);
        #1;
        expect_rsp("R8", 1, 1, 0, 24'hE00000, 0, 0);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R8", "rsp_valid drops", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_fill();
        t_probe();
        t_rewrite();
        t_evict();
        t_reserved();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule